// File: doc/BRIEF.md
# Stage Event Timestamp Recorder

This block keeps a timing record for one command of a block-processing accelerator whose load, compute and store stages overlap. The pipeline sends it a single-cycle strobe at each of seven stage boundaries: command arrival, load begin, load end, compute begin, store begin, store end and response sent. Arrival opens a fresh record and sets the time origin. Every later boundary is stored as the number of cycles that have passed since that origin.

The record can be read one event at a time through a select input. Each read gives the stored offset, whether that event has been captured yet, and whether it is a bus-visible boundary (the spans around the input read burst and the output write burst, plus the response) or an internal one (arrival and compute begin). When compute begins, the block also latches the compute body duration that comes with the strobe. A flag shows when all seven events are present. A sticky error bit shows that some event was strobed twice within one command.

Top module: `evrec_top`

## Requirements
- R1: After reset no event is captured, `complete_o` and `dup_err_o` are 0, and `comp_dur_o` is 0.
- R2: An arrival strobe starts a new record one cycle later. Only the arrival (select 0) is then captured, with offset 0. The error bit and the compute duration are cleared.
- R3: An event other than arrival, strobed k clock edges after the arrival edge, is stored with offset k modulo 2^TS_W.
- R4: An event strobe while no record is open (no arrival since reset) has no effect.
- R5: A second strobe for an event that is already captured in the open record leaves the stored offset unchanged. It sets `dup_err_o`, which stays set until the next arrival.
- R6: `complete_o` is 1 exactly when all seven events of the open record are captured.
- R7: The first accepted compute-begin strobe latches `comp_dur_i` into `comp_dur_o`. A duplicate compute-begin strobe does not change it.
- R8: The select codes are 0 arrival, 1 load begin, 2 load end, 3 compute begin, 4 store begin, 5 store end, 6 response. `rd_bus_vis_o` is 1 for codes 1, 2, 4, 5 and 6, and 0 for codes 0 and 3.
- R9: Select code 7 reads back `rd_valid_o`=0, `rd_offset_o`=0 and `rd_bus_vis_o`=0. For codes 0 to 6, an event that is not captured reads offset 0 with valid 0.
- R10: An event strobed in the same cycle as an arrival belongs to the new record, with offset 0.
- R11: Offsets wrap modulo 2^TS_W when an event comes more than 2^TS_W-1 cycles after arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_arrive_i | input | 1 | Command arrival strobe |
| ev_load_beg_i | input | 1 | Input read burst begins |
| ev_load_end_i | input | 1 | Input read burst ends |
| ev_comp_beg_i | input | 1 | Compute begins |
| ev_store_beg_i | input | 1 | Output write burst begins |
| ev_store_end_i | input | 1 | Output write burst ends |
| ev_resp_i | input | 1 | Response sent |
| comp_dur_i | input | DUR_W | Compute body duration, valid with `ev_comp_beg_i` |
| rd_sel_i | input | 3 | Event select for readout |
| rd_offset_o | output | TS_W | Stored offset of the selected event |
| rd_valid_o | output | 1 | Selected event is captured |
| rd_bus_vis_o | output | 1 | Selected event is bus-visible |
| captured_o | output | 7 | Captured flag per event, bit index = select code |
| complete_o | output | 1 | All seven events captured |
| dup_err_o | output | 1 | Sticky duplicate-strobe error |
| comp_dur_o | output | DUR_W | Latched compute body duration |

## Verification
The assertions assume that each strobe lasts one cycle and is sampled on the rising edge. They assume the select input is any 3-bit value and that the compute duration is meaningful only alongside its strobe. The assertions are written so that they hold for any ordering of strobes: the block itself does not enforce that response comes after store end. The stimulus still follows the natural order for normal commands. It strays from that order only on purpose: strobes before any arrival, repeated strobes, an arrival together with compute begin, and an event delayed past the counter wrap. Every select code is swept after every clock.

// File: rtl/evrec_pkg.sv
package evrec_pkg;

  localparam int N_EV  = 7;
  localparam int SEL_W = $clog2(N_EV + 1);

  typedef enum logic [SEL_W-1:0] {
    EV_ARRIVE    = 3'd0,
    EV_LOAD_BEG  = 3'd1,
    EV_LOAD_END  = 3'd2,
    EV_COMP_BEG  = 3'd3,
    EV_STORE_BEG = 3'd4,
    EV_STORE_END = 3'd5,
    EV_RESP      = 3'd6
  } ev_id_e;

  // Bit i set: event i lies on a memory-transfer or response boundary.
  localparam logic [N_EV-1:0] BUS_VIS_MASK = 7'b111_0110;

  function automatic logic is_bus_visible(input logic [SEL_W-1:0] sel);
    return (int'(sel) < N_EV) ? BUS_VIS_MASK[sel] : 1'b0;
  endfunction

  function automatic logic sel_in_range(input logic [SEL_W-1:0] sel);
    return int'(sel) < N_EV;
  endfunction

endpackage

// File: rtl/evrec_timebase.sv
module evrec_timebase #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arrive_i,
  output logic [TS_W-1:0] offset_o
);

  logic [TS_W-1:0] now_q;
  logic [TS_W-1:0] base_q;

  // Modular distance from the anchor to the present cycle.
  function automatic logic [TS_W-1:0] span(input logic [TS_W-1:0] now,
                                           input logic [TS_W-1:0] base);
    return now - base;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q  <= '0;
      base_q <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (arrive_i) base_q <= now_q;
    end
  end

  // An event coinciding with arrival sits at the origin.
  assign offset_o = arrive_i ? '0 : span(now_q, base_q);

endmodule

// File: rtl/evrec_slot.sv
module evrec_slot #(
  parameter int TS_W      = 16,
  parameter bit IS_ANCHOR = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arrive_i,
  input  logic            open_i,
  input  logic            strobe_i,
  input  logic [TS_W-1:0] offset_i,
  output logic            captured_o,
  output logic [TS_W-1:0] value_o,
  output logic            hit_o,
  output logic            dup_o
);

  logic            cap_q;
  logic [TS_W-1:0] val_q;

  generate
    if (IS_ANCHOR) begin : g_anchor
      assign hit_o = arrive_i;
      assign dup_o = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cap_q <= 1'b0;
          val_q <= '0;
        end else if (arrive_i) begin
          cap_q <= 1'b1;
          val_q <= '0;
        end
      end
    end else begin : g_event
      // Captured state that is about to be discarded by an arrival counts as empty.
      logic held;
      assign held  = cap_q & ~arrive_i;
      assign hit_o = strobe_i & open_i & ~held;
      assign dup_o = strobe_i & open_i & held;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cap_q <= 1'b0;
          val_q <= '0;
        end else if (hit_o) begin
          cap_q <= 1'b1;
          val_q <= offset_i;
        end else if (arrive_i) begin
          cap_q <= 1'b0;
          val_q <= '0;
        end
      end
    end
  endgenerate

  assign captured_o = cap_q;
  assign value_o    = val_q;

endmodule

// File: rtl/evrec_readout.sv
module evrec_readout
  import evrec_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [N_EV-1:0]            captured_i,
  input  logic [N_EV-1:0][TS_W-1:0]  values_i,
  output logic [TS_W-1:0]            offset_o,
  output logic                       valid_o,
  output logic                       bus_vis_o
);

  always_comb begin
    offset_o  = '0;
    valid_o   = 1'b0;
    bus_vis_o = is_bus_visible(sel_i);
    if (sel_in_range(sel_i)) begin
      valid_o = captured_i[sel_i[SEL_W-1:0]];
      if (valid_o) offset_o = values_i[sel_i[SEL_W-1:0]];
    end
  end

endmodule

// File: rtl/evrec_top.sv
module evrec_top
  import evrec_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int DUR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_arrive_i,
  input  logic                 ev_load_beg_i,
  input  logic                 ev_load_end_i,
  input  logic                 ev_comp_beg_i,
  input  logic                 ev_store_beg_i,
  input  logic                 ev_store_end_i,
  input  logic                 ev_resp_i,
  input  logic [DUR_W-1:0]     comp_dur_i,
  input  logic [SEL_W-1:0]     rd_sel_i,
  output logic [TS_W-1:0]      rd_offset_o,
  output logic                 rd_valid_o,
  output logic                 rd_bus_vis_o,
  output logic [N_EV-1:0]      captured_o,
  output logic                 complete_o,
  output logic                 dup_err_o,
  output logic [DUR_W-1:0]     comp_dur_o
);

  logic [N_EV-1:0]           strobes;
  logic [N_EV-1:0]           slot_hit;
  logic [N_EV-1:0]           slot_dup;
  logic [N_EV-1:0][TS_W-1:0] slot_val;
  logic [TS_W-1:0]           cur_offset;
  logic                      arrive_fire;
  logic                      rec_open;
  logic                      dup_q;
  logic [DUR_W-1:0]          dur_q;

  assign strobes = {ev_resp_i, ev_store_end_i, ev_store_beg_i,
                    ev_comp_beg_i, ev_load_end_i, ev_load_beg_i, ev_arrive_i};

  assign arrive_fire = ev_arrive_i;
  // A record is open once the anchor is held, or in the arrival cycle itself.
  assign rec_open    = captured_o[EV_ARRIVE] | arrive_fire;

  evrec_timebase #(.TS_W(TS_W)) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .arrive_i (arrive_fire),
    .offset_o (cur_offset)
  );

  for (genvar e = 0; e < N_EV; e++) begin : g_slot
    evrec_slot #(
      .TS_W      (TS_W),
      .IS_ANCHOR (e == int'(EV_ARRIVE))
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .arrive_i   (arrive_fire),
      .open_i     (rec_open),
      .strobe_i   (strobes[e]),
      .offset_i   (cur_offset),
      .captured_o (captured_o[e]),
      .value_o    (slot_val[e]),
      .hit_o      (slot_hit[e]),
      .dup_o      (slot_dup[e])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dup_q <= 1'b0;
      dur_q <= '0;
    end else begin
      if (arrive_fire)    dup_q <= 1'b0;
      else if (|slot_dup) dup_q <= 1'b1;
      if (slot_hit[EV_COMP_BEG]) dur_q <= comp_dur_i;
      else if (arrive_fire)      dur_q <= '0;
    end
  end

  assign dup_err_o  = dup_q;
  assign comp_dur_o = dur_q;
  assign complete_o = &captured_o;

  evrec_readout #(.TS_W(TS_W)) u_read (
    .sel_i      (rd_sel_i),
    .captured_i (captured_o),
    .values_i   (slot_val),
    .offset_o   (rd_offset_o),
    .valid_o    (rd_valid_o),
    .bus_vis_o  (rd_bus_vis_o)
  );

endmodule

// File: rtl/evrec_chk.sv
module evrec_chk
  import evrec_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int DUR_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 arrive_fire,
  input logic [N_EV-1:0]      slot_hit,
  input logic [N_EV-1:0]      slot_dup,
  input logic [N_EV-1:0]      captured_o,
  input logic                 dup_err_o,
  input logic                 complete_o,
  input logic [DUR_W-1:0]     comp_dur_i,
  input logic [DUR_W-1:0]     comp_dur_o,
  input logic [SEL_W-1:0]     rd_sel_i,
  input logic                 rd_valid_o,
  input logic [TS_W-1:0]      rd_offset_o,
  input logic                 rd_bus_vis_o
);

  assert_anchor_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arrive_fire |=> (captured_o[0] && !dup_err_o));

  assert_anchor_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_i == 3'd0 && rd_valid_o) |-> (rd_offset_o == '0));

  assert_idle_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !captured_o[0] |-> (captured_o == '0));

  assert_keep_captured_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !arrive_fire |=> ((captured_o & $past(captured_o)) == $past(captured_o)));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_err_o && !arrive_fire) |=> dup_err_o);

  assert_dup_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_dup) |=> dup_err_o);

  assert_complete_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(complete_o) |-> $past(|slot_hit));

  assert_dur_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_hit[3] |=> (comp_dur_o == $past(comp_dur_i)));

  assert_sel_oob_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_i == 3'd7) |-> (!rd_valid_o && !rd_bus_vis_o && rd_offset_o == '0));

endmodule

bind evrec_top evrec_chk #(.TS_W(TS_W), .DUR_W(DUR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .arrive_fire  (arrive_fire),
  .slot_hit     (slot_hit),
  .slot_dup     (slot_dup),
  .captured_o   (captured_o),
  .dup_err_o    (dup_err_o),
  .complete_o   (complete_o),
  .comp_dur_i   (comp_dur_i),
  .comp_dur_o   (comp_dur_o),
  .rd_sel_i     (rd_sel_i),
  .rd_valid_o   (rd_valid_o),
  .rd_offset_o  (rd_offset_o),
  .rd_bus_vis_o (rd_bus_vis_o)
);

// File: tb/evrec_top_tb_top.sv
module evrec_top_tb_top;

  localparam int CLK_PERIOD = 20;
  localparam int TS_W  = 8;
  localparam int DUR_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [6:0]       stb = '0;
  logic [DUR_W-1:0] dur_in = '0;
  logic [2:0]       rd_sel = '0;
  logic [TS_W-1:0]  rd_offset;
  logic             rd_valid, rd_bus_vis, complete, dup_err;
  logic [6:0]       captured;
  logic [DUR_W-1:0] dur_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // Reference model state
  int  t = 0;
  int  t_anchor = 0;
  bit  m_cap [7];
  int  m_off [7];
  bit  m_err = 0;
  int  m_dur = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evrec_top #(.TS_W(TS_W), .DUR_W(DUR_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_arrive_i(stb[0]), .ev_load_beg_i(stb[1]), .ev_load_end_i(stb[2]),
    .ev_comp_beg_i(stb[3]), .ev_store_beg_i(stb[4]), .ev_store_end_i(stb[5]),
    .ev_resp_i(stb[6]), .comp_dur_i(dur_in), .rd_sel_i(rd_sel),
    .rd_offset_o(rd_offset), .rd_valid_o(rd_valid), .rd_bus_vis_o(rd_bus_vis),
    .captured_o(captured), .complete_o(complete), .dup_err_o(dup_err),
    .comp_dur_o(dur_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, t);
    end
  endtask

  function automatic bit exp_bus(input int s);
    return (s == 1 || s == 2 || s == 4 || s == 5 || s == 6);
  endfunction

  // Model update for one rising edge with the given strobes
  task automatic model_edge(input logic [6:0] s, input int d);
    if (s[0]) begin
      foreach (m_cap[i]) begin m_cap[i] = 0; m_off[i] = 0; end
      m_cap[0] = 1; m_err = 0; m_dur = 0; t_anchor = t;
    end
    if (m_cap[0]) begin
      for (int e = 1; e < 7; e++) begin
        if (s[e]) begin
          if (m_cap[e]) m_err = 1;
          else begin
            m_cap[e] = 1;
            m_off[e] = (t - t_anchor) % (1 << TS_W);
            if (e == 3) m_dur = d;
          end
        end
      end
    end
  endtask

  task automatic compare_all();
    int all = 1;
    for (int s = 0; s < 8; s++) begin
      bit v;
      rd_sel = 3'(s);
      #1;
      v = (s < 7) ? m_cap[s] : 0;
      check(rd_valid == v, (s == 7) ? "R9" : "R2", int'(rd_valid), int'(v));
      check(int'(rd_offset) == (v ? m_off[s] : 0), (s == 7) ? "R9" : "R3",
            int'(rd_offset), v ? m_off[s] : 0);
      check(rd_bus_vis == exp_bus(s), "R8", int'(rd_bus_vis), int'(exp_bus(s)));
    end
    for (int e = 0; e < 7; e++) if (!m_cap[e]) all = 0;
    check(complete == all[0], "R6", int'(complete), all);
    check(dup_err == m_err, "R5", int'(dup_err), int'(m_err));
    check(int'(dur_out) == m_dur, "R7", int'(dur_out), m_dur);
  endtask

  task automatic step(input logic [6:0] s, input int d = 0);
    @(negedge clk);
    stb = s;
    dur_in = DUR_W'(d);
    @(posedge clk);
    model_edge(s, d);
    t++;
    #1;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(7'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    foreach (m_cap[i]) begin m_cap[i] = 0; m_off[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: reset state
    check(captured == 7'b0, "R1", int'(captured), 0);
    check(!complete && !dup_err, "R1", int'({complete, dup_err}), 0);
    check(dur_out == '0, "R1", int'(dur_out), 0);
    compare_all();

    // R4: strobes with no open record are ignored
    step(7'b111_1110, 33);
    idle(2);
    check(captured == 7'b0, "R4", int'(captured), 0);

    // R2/R3/R6: ordered command
    step(7'b000_0001);
    idle(2);
    step(7'b000_0010);
    idle(4);
    step(7'b000_0100);
    step(7'b000_1000, 777);
    idle(5);
    step(7'b001_0000);
    idle(3);
    step(7'b010_0000);
    step(7'b100_0000);
    check(complete == 1'b1, "R6", int'(complete), 1);

    // R5/R7: duplicates keep values and set the sticky error
    step(7'b000_1100, 99);
    idle(2);
    check(dup_err == 1'b1, "R5", int'(dup_err), 1);
    check(int'(dur_out) == 777, "R7", int'(dur_out), 777);

    // R2/R10: new arrival with compute begin in the same cycle
    step(7'b000_1001, 512);
    check(dup_err == 1'b0, "R2", int'(dup_err), 0);
    check(captured == 7'b000_1001, "R10", int'(captured), 9);
    idle(1);
    step(7'b010_0010);
    step(7'b000_0100);

    // R11: offsets wrap past 2^TS_W
    step(7'b000_0001);
    idle(299);
    step(7'b000_0010);
    rd_sel = 3'd1;
    #1;
    check(int'(rd_offset) == 300 % 256, "R11", int'(rd_offset), 300 % 256);

    // Back-to-back arrivals and a response right after arrival
    step(7'b000_0001);
    step(7'b100_0001);
    step(7'b100_0000);
    idle(2);

    finished = 1;
    finish_run();
  end

endmodule